// File: doc/BRIEF.md
# Programmable Step Up/Down Accumulator

This block holds a 10-bit value for a digital calibration loop and moves it by a power-of-two step on every enabled clock. A 3-bit exponent picks a step of 1, 2, 4, 8 or 16. A direction bit chooses whether the step is added or taken away. One correction is applied per cycle, so the loop sees a new value every clock.

The adder is split at bit 5. The low five bits go through a ripple chain. The high five bits are computed twice, once for each possible carry into them, and the carry or borrow out of the low half picks one of the two. Subtraction adds the inverted step with a carry-in of one.

A mode input sets what happens when an update would leave the 0..1023 range. In wrap mode the value wraps modulo 1024 and a one-cycle flag reports the wrap. In saturate mode the value clamps at the range edge and a sticky flag records the clamp. A synchronous reset loads a parameterised start value, which is mid-scale (512) by default.

Top module: `step_accum`

## Requirements
- R1: While `rst` is high at a clock edge, the value becomes 512 (the default start value), and `clamp_flag` and `wrap_flag` both become 0.
- R2: With `en`=1 and `dir`=0 (increment), an exponent code n in 0..4 adds 2^n to the value, and the result is visible after that edge.
- R3: With `en`=1 and `dir`=1 (decrement), an exponent code n in 0..4 subtracts 2^n from the value.
- R4: With `en`=0, the value is held, whatever `dir`, `step_exp` and `sat_mode` are.
- R5: Exponent codes 5, 6 and 7 are ignored. With `en`=1 the value holds, and neither flag is set by that update.
- R6: With `sat_mode`=0 (wrap), a result outside 0..1023 wraps modulo 1024. `wrap_flag` is 1 in the cycle after a wrapping update and 0 after every other clock.
- R7: With `sat_mode`=1 (saturate), a result above 1023 becomes 1023 and a result below 0 becomes 0. `clamp_flag` goes to 1 on such a clamp and stays at 1 until reset. `wrap_flag` stays 0 in this mode.
- R8: Back-to-back enabled updates with any mix of direction, exponent and mode each take effect on consecutive clocks, with no stall cycles.
- R9: A carry out of bit 4 when incrementing, or a borrow into bit 5 when decrementing, correctly updates the upper half (for example 31+1=32 and 32-1=31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the start value |
| en | input | 1 | Update enable |
| dir | input | 1 | 0 = increment, 1 = decrement |
| step_exp | input | 3 | Step exponent n; step is 2^n for n = 0..4, codes 5..7 ignored |
| sat_mode | input | 1 | 0 = wrap at the range edges, 1 = saturate |
| acc_out | output | 10 | Registered accumulator value |
| clamp_flag | output | 1 | Sticky; set when a saturating clamp occurred |
| wrap_flag | output | 1 | High for the cycle after an update that wrapped |

## Verification
The range edges are the hardest to reach from the ports. They lie up to 512 counts from the start value, and a clamp or wrap needs the value within one step of 0 or 1023. The stimulus walks there with long runs of the largest step, then crosses the edge in both modes and in both directions. A reset followed by coarse and fine decrements parks the value at 31/32, so the carry and borrow across the split at bit 5 are exercised. A long random run of direction, exponent, enable and mode then checks that updates are applied every cycle.

// File: rtl/step_accum_pkg.sv
package step_accum_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } step_dir_e;

    typedef enum logic {
        EDGE_WRAP = 1'b0,
        EDGE_SAT  = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/ripple_addsub.sv
module ripple_addsub #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign cout = carry[W];

    // The gate chain must agree with plain arithmetic (R2, R3)
    always_comb begin
        assert_chain_arith_R2: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)));
    end

endmodule

// File: rtl/carry_select_half.sv
module carry_select_half #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel_cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] sum_c0, sum_c1;
    logic         co_c0, co_c1;

    ripple_addsub #(.W(W)) u_c0 (
        .a(a), .b(b), .cin(1'b0), .sum(sum_c0), .cout(co_c0)
    );

    ripple_addsub #(.W(W)) u_c1 (
        .a(a), .b(b), .cin(1'b1), .sum(sum_c1), .cout(co_c1)
    );

    assign sum  = sel_cin ? sum_c1 : sum_c0;
    assign cout = sel_cin ? co_c1  : co_c0;

    // The two precomputed results differ by exactly one (R9)
    always_comb begin
        assert_select_pair_R9: assert ({co_c1, sum_c1} == ({co_c0, sum_c0} + (W+1)'(1)));
    end

endmodule

// File: rtl/step_operand_gen.sv
module step_operand_gen #(
    parameter int WIDTH   = 10,
    parameter int EXP_W   = 3,
    parameter int MAX_EXP = 4
) (
    input  logic [EXP_W-1:0] step_exp,
    input  logic             dir,
    output logic [WIDTH-1:0] operand,
    output logic             cin,
    output logic             legal
);
    logic [WIDTH-1:0] onehot;

    assign legal = (int'(step_exp) <= MAX_EXP);

    for (genvar i = 0; i < WIDTH; i++) begin : g_step
        if (i <= MAX_EXP) begin : g_live
            assign onehot[i] = legal && (int'(step_exp) == i);
        end else begin : g_dead
            assign onehot[i] = 1'b0;
        end
    end

    // Decrement: add the two's complement (invert, carry in one)
    assign operand = onehot ^ {WIDTH{dir}};
    assign cin     = dir;

    always_comb begin
        assert_step_onehot_R5: assert ($onehot0(onehot) && (legal || onehot == '0));
    end

endmodule

// File: rtl/step_accum.sv
module step_accum #(
    parameter int ACC_W      = 10,
    parameter int LO_W       = 5,
    parameter int EXP_W      = 3,
    parameter int MAX_EXP    = 4,
    parameter int INIT_VALUE = 1 << (ACC_W - 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             dir,
    input  logic [EXP_W-1:0] step_exp,
    input  logic             sat_mode,
    output logic [ACC_W-1:0] acc_out,
    output logic             clamp_flag,
    output logic             wrap_flag
);
    import step_accum_pkg::*;

    localparam int               HI_W     = ACC_W - LO_W;
    localparam logic [ACC_W-1:0] FULL_VAL = '1;
    localparam logic [ACC_W-1:0] INIT_VAL = ACC_W'(INIT_VALUE);

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             clamp;
        logic             wrap;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [ACC_W-1:0] operand;
    logic             op_cin, op_legal;
    logic [LO_W-1:0]  lo_sum;
    logic             lo_cout;
    logic [HI_W-1:0]  hi_sum;
    logic             hi_cout;
    logic [ACC_W-1:0] next_sum;
    logic             range_exit;

    step_operand_gen #(
        .WIDTH(ACC_W), .EXP_W(EXP_W), .MAX_EXP(MAX_EXP)
    ) u_step (
        .step_exp(step_exp), .dir(dir),
        .operand(operand), .cin(op_cin), .legal(op_legal)
    );

    ripple_addsub #(.W(LO_W)) u_lo (
        .a(st_q.acc[LO_W-1:0]), .b(operand[LO_W-1:0]), .cin(op_cin),
        .sum(lo_sum), .cout(lo_cout)
    );

    carry_select_half #(.W(HI_W)) u_hi (
        .a(st_q.acc[ACC_W-1:LO_W]), .b(operand[ACC_W-1:LO_W]), .sel_cin(lo_cout),
        .sum(hi_sum), .cout(hi_cout)
    );

    assign next_sum = {hi_sum, lo_sum};
    // Increment leaves the range on carry out; decrement on missing carry (borrow)
    assign range_exit = (dir == DIR_DOWN) ? ~hi_cout : hi_cout;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        if (en && op_legal) begin
            if (range_exit && (sat_mode == EDGE_SAT)) begin
                st_d.acc   = (dir == DIR_DOWN) ? '0 : FULL_VAL;
                st_d.clamp = 1'b1;
            end else begin
                st_d.acc  = next_sum;
                st_d.wrap = range_exit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc   <= INIT_VAL;
            st_q.clamp <= 1'b0;
            st_q.wrap  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out    = st_q.acc;
    assign clamp_flag = st_q.clamp;
    assign wrap_flag  = st_q.wrap;

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc_out));

    assert_bad_exp_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (en && int'(step_exp) > MAX_EXP) |=> ($stable(acc_out) && !wrap_flag));

    assert_clamp_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        clamp_flag |=> clamp_flag);

    assert_no_wrap_in_sat_R6: assert property (@(posedge clk) disable iff (rst)
        sat_mode |=> !wrap_flag);

    assert_sat_up_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        (en && !dir && sat_mode) |=> (acc_out >= $past(acc_out)));

    assert_sat_down_monotone_R7: assert property (@(posedge clk) disable iff (rst)
        (en && dir && sat_mode) |=> (acc_out <= $past(acc_out)));

endmodule

// File: tb/sim_step_accum.sv
module sim_step_accum;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       dir = 1'b0;
    logic [2:0] step_exp = 3'd0;
    logic       sat_mode = 1'b0;
    logic [9:0] acc_out;
    logic       clamp_flag;
    logic       wrap_flag;

    always #5 clk = ~clk;

    step_accum u0 (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .step_exp(step_exp),
        .sat_mode(sat_mode), .acc_out(acc_out), .clamp_flag(clamp_flag),
        .wrap_flag(wrap_flag)
    );

    typedef struct {
        int    acc;
        bit    clamp;
        bit    wrap;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int  checks   = 0;
    int  failures = 0;
    int  m_acc    = 512;
    bit  m_clamp  = 0;
    bit  done     = 0;

    // Driver: set inputs for the next edge and push the expected result
    task automatic drive(input bit r, input bit e, input bit d, input int x,
                         input bit s, input string tag);
        exp_item_t it;
        int v;
        bit w;
        @(negedge clk);
        rst = r; en = e; dir = d; step_exp = 3'(x); sat_mode = s;
        w = 0;
        if (r) begin
            m_acc = 512; m_clamp = 0;
        end else if (e && x <= 4) begin
            v = d ? m_acc - (1 << x) : m_acc + (1 << x);
            if (v < 0 || v > 1023) begin
                if (s) begin
                    m_acc = d ? 0 : 1023; m_clamp = 1;
                end else begin
                    m_acc = (v + 1024) % 1024; w = 1;
                end
            end else begin
                m_acc = v;
            end
        end
        it.acc = m_acc; it.clamp = m_clamp; it.wrap = w; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare after every edge that had an expectation queued
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (acc_out != 10'(it.acc) || clamp_flag != it.clamp || wrap_flag != it.wrap) begin
                    failures++;
                    $display("FAIL %s: acc=%0d clamp=%0d wrap=%0d expected acc=%0d clamp=%0d wrap=%0d",
                             it.tag, acc_out, clamp_flag, wrap_flag, it.acc, it.clamp, it.wrap);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        drive(1, 0, 0, 0, 0, "R1");
        drive(1, 1, 0, 4, 1, "R1");
        // R2 increments with every legal exponent
        for (int n = 0; n <= 4; n++) drive(0, 1, 0, n, 0, "R2");
        // R3 decrements with every legal exponent
        for (int n = 0; n <= 4; n++) drive(0, 1, 1, n, 0, "R3");
        // R4 enable low holds
        for (int n = 0; n < 8; n++) drive(0, 0, n[0], n, n[1], "R4");
        // R5 illegal exponent codes are ignored
        for (int n = 5; n <= 7; n++) drive(0, 1, 0, n, 0, "R5");
        for (int n = 5; n <= 7; n++) drive(0, 1, 1, n, 1, "R5");
        // R6 wrap upward, then downward
        for (int k = 0; k < 40; k++) drive(0, 1, 0, 4, 0, "R6");
        for (int k = 0; k < 70; k++) drive(0, 1, 1, 4, 0, "R6");
        // R7 saturate at top, then bottom; flag stays after mode change
        drive(1, 0, 0, 0, 0, "R1");
        for (int k = 0; k < 40; k++) drive(0, 1, 0, 4, 1, "R7");
        for (int k = 0; k < 3; k++) drive(0, 1, 0, 0, 1, "R7");
        for (int k = 0; k < 80; k++) drive(0, 1, 1, 3, 1, "R7");
        for (int k = 0; k < 4; k++) drive(0, 1, 1, 2, 0, "R7");
        // R9 carry and borrow across bit 5
        drive(1, 0, 0, 0, 0, "R1");
        for (int k = 0; k < 30; k++) drive(0, 1, 1, 4, 0, "R9");
        drive(0, 1, 1, 0, 0, "R9");
        drive(0, 1, 0, 0, 0, "R9");
        drive(0, 1, 1, 0, 0, "R9");
        drive(0, 1, 0, 2, 0, "R9");
        drive(0, 1, 1, 3, 0, "R9");
        // R8 random back-to-back traffic
        drive(1, 0, 0, 0, 0, "R1");
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 255));
            drive(0, r[7:5] != 3'd0, r[4], r[2:0], (k / 500) % 2 == 1, "R8");
        end
        @(negedge clk);
        en = 0;
        while (sb_q.size() > 0) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule